// File: doc/BRIEF.md
# Long Branch-With-Link Sequencer

This block drives the bus cycles and link-register writes of a subroutine call whose offset is split across two consecutive 16-bit instructions. The first instruction works as a plain data operation. It adds the program counter to the sign-extended high part of the offset and writes the sum to the link register. The second instruction completes the call. It forms the final target from that partial sum and the low part of the offset, moves fetching to the target, and stores a return address. One cycle later it stores that return address minus two, so that a subroutine which saves the link register on a stack and later loads it into the program counter returns to the right place.

The instruction decoder pulses `start` while the sequencer is idle. With that pulse it supplies the address of the first halfword and the two 11-bit offset fields that it has already pulled out of the halfwords. The sequencer then issues four halfword read requests. Each one waits for `mem_ready`. It writes the link register through a simple write port. When the operation finishes it pulses `done` and shows the address from which sequential fetching resumes.

The controller has six states:
- IDLE: waiting for a start pulse.
- HEAD: cycle 1, the first instruction.
- REDIR: cycle 2, prefetch while the target is computed.
- TARGET: cycle 3, fetch from the target.
- REFILL: cycle 4, fetch from the target plus two.
- FIN: one-cycle completion.

Its transitions are:
- IDLE→HEAD when `start` is high.
- HEAD→REDIR, REDIR→TARGET, TARGET→REFILL and REFILL→FIN, each on a clock edge with `mem_ready` high. Each of these states holds while `mem_ready` is low.
- FIN→IDLE always.
- Any state→IDLE on reset.

Top module: `lbl_seq`

## Requirements
- R1: After reset, and whenever the sequencer is idle or finishing, `req_n`=1, `opc_n`=1, `lr_we`=0. After reset and in idle, `done`=0.
- R2: `pc_in`, `hi_offset` and `lo_offset` are captured on the edge where `start` is accepted in IDLE. Later changes to them have no effect on the running operation. `start` outside IDLE is ignored.
- R3: Cycle 1 (HEAD) has `fetch_addr`=pc+4 and `seq`=1. When it is accepted, it writes head = pc+4+(sign-extended `hi_offset`<<12) to the link register.
- R4: Cycle 2 (REDIR) has `fetch_addr`=pc+6 and `seq`=0, and no link-register write.
- R5: Cycle 3 (TARGET) has `fetch_addr`=target = head + (zero-extended `lo_offset`<<1) and `seq`=1. It writes the return address pc+6 to the link register.
- R6: Cycle 4 (REFILL) has `fetch_addr`=target+2 and `seq`=1. It writes the return address minus two (pc+4) to the link register.
- R7: In all four bus cycles, `acc_size`=2'b01 (halfword), `bus_wr`=0 (read), `req_n`=0 and `opc_n`=0.
- R8: A bus cycle advances only on a clock edge with `mem_ready`=1. While `mem_ready`=0, `fetch_addr` and `seq` hold and `lr_we`=0, so each write happens exactly once.
- R9: `done` is high for exactly the one cycle after cycle 4 is accepted. In that cycle `resume_addr`=target+4. The cycle after it is idle.
- R10: All address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (sampled in IDLE only) |
| pc_in | input | 32 | Address of the first halfword |
| hi_offset | input | 11 | Offset field of the first halfword |
| lo_offset | input | 11 | Offset field of the second halfword |
| mem_ready | input | 1 | Memory accepts the current bus cycle |
| fetch_addr | output | 32 | Fetch address |
| acc_size | output | 2 | Access size code, 01 = halfword |
| bus_wr | output | 1 | 1 = write, 0 = read |
| req_n | output | 1 | Memory request, active low |
| seq | output | 1 | Sequential access |
| opc_n | output | 1 | Opcode fetch, active low |
| lr_we | output | 1 | Link-register write enable |
| lr_wdata | output | 32 | Link-register write data |
| done | output | 1 | One-cycle completion pulse |
| resume_addr | output | 32 | Next fetch address, valid with `done` |

## Verification
On every cycle, the assertions check the bus encoding of an active request. They also check that address and sequential strobe hold, and that the link-register write is withheld, during a stall. They check that a non-sequential request is always followed by a sequential one, and that `done` is a single idle-cycle pulse. The exact address values are checked only by the bench's scenarios: the head sum, the target, target+2 and target+4, including negative high offsets and wraparound. So are the three link-register values and their order, the capture of inputs at start, and recovery from a reset in mid-operation.

// File: rtl/lbl_pkg.sv
package lbl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_HEAD   = 3'd1,
        ST_REDIR  = 3'd2,
        ST_TARGET = 3'd3,
        ST_REFILL = 3'd4,
        ST_FIN    = 3'd5
    } lbl_state_e;

    localparam logic [1:0] SIZE_HALF  = 2'b01;
    localparam int         HALF_BYTES = 2;
endpackage

// File: rtl/lbl_capture.sv
module lbl_capture #(
    parameter int AW   = 32,
    parameter int OFFW = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [AW-1:0]   pc_in,
    input  logic [OFFW-1:0] hi_in,
    input  logic [OFFW-1:0] lo_in,
    output logic [AW-1:0]   pc_q,
    output logic [OFFW-1:0] hi_q,
    output logic [OFFW-1:0] lo_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
            hi_q <= '0;
            lo_q <= '0;
        end else if (load) begin
            pc_q <= pc_in;
            hi_q <= hi_in;
            lo_q <= lo_in;
        end
    end
endmodule

// File: rtl/lbl_addr_calc.sv
module lbl_addr_calc #(
    parameter int AW       = 32,
    parameter int OFFW     = 11,
    parameter int HI_SHIFT = 12
) (
    input  logic [AW-1:0]   pc_q,
    input  logic [OFFW-1:0] hi_q,
    input  logic [OFFW-1:0] lo_q,
    output logic [AW-1:0]   addr_head,
    output logic [AW-1:0]   addr_redir,
    output logic [AW-1:0]   head_sum,
    output logic [AW-1:0]   target,
    output logic [AW-1:0]   target_p2,
    output logic [AW-1:0]   target_p4,
    output logic [AW-1:0]   ret_addr,
    output logic [AW-1:0]   ret_fixed
);
    localparam int          EXTW  = AW - OFFW;
    localparam logic [AW-1:0] STEP  = AW'(lbl_pkg::HALF_BYTES);
    localparam logic [AW-1:0] STEP2 = AW'(2 * lbl_pkg::HALF_BYTES);
    localparam logic [AW-1:0] STEP3 = AW'(3 * lbl_pkg::HALF_BYTES);

    logic [AW-1:0] hi_ext;
    logic [AW-1:0] lo_ext;

    // high part: sign extended, scaled; low part: zero extended, halfword scaled
    assign hi_ext = {{EXTW{hi_q[OFFW-1]}}, hi_q} << HI_SHIFT;
    assign lo_ext = {{EXTW{1'b0}}, lo_q} << 1;

    assign addr_head  = pc_q + STEP2;
    assign addr_redir = pc_q + STEP3;
    assign head_sum   = addr_head + hi_ext;
    assign target     = head_sum + lo_ext;
    assign target_p2  = target + STEP;
    assign target_p4  = target + STEP2;
    assign ret_addr   = addr_redir;
    assign ret_fixed  = ret_addr - STEP;
endmodule

// File: rtl/lbl_fsm.sv
module lbl_fsm
    import lbl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       mem_ready,
    output lbl_state_e state,
    output logic       accept
);
    lbl_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt    = state;
        accept = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    nxt    = ST_HEAD;
                    accept = 1'b1;
                end
            end
            ST_HEAD:   if (mem_ready) nxt = ST_REDIR;
            ST_REDIR:  if (mem_ready) nxt = ST_TARGET;
            ST_TARGET: if (mem_ready) nxt = ST_REFILL;
            ST_REFILL: if (mem_ready) nxt = ST_FIN;
            ST_FIN:    nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/lbl_bus_drive.sv
module lbl_bus_drive
    import lbl_pkg::*;
#(
    parameter int AW = 32
) (
    input  lbl_state_e    state,
    input  logic          mem_ready,
    input  logic [AW-1:0] addr_head,
    input  logic [AW-1:0] addr_redir,
    input  logic [AW-1:0] head_sum,
    input  logic [AW-1:0] target,
    input  logic [AW-1:0] target_p2,
    input  logic [AW-1:0] target_p4,
    input  logic [AW-1:0] ret_addr,
    input  logic [AW-1:0] ret_fixed,
    output logic [AW-1:0] fetch_addr,
    output logic [1:0]    acc_size,
    output logic          bus_wr,
    output logic          req_n,
    output logic          seq,
    output logic          opc_n,
    output logic          lr_we,
    output logic [AW-1:0] lr_wdata,
    output logic          done,
    output logic [AW-1:0] resume_addr
);
    always_comb begin
        fetch_addr  = '0;
        acc_size    = SIZE_HALF;
        bus_wr      = 1'b0;
        req_n       = 1'b1;
        seq         = 1'b0;
        opc_n       = 1'b1;
        lr_we       = 1'b0;
        lr_wdata    = '0;
        done        = 1'b0;
        resume_addr = '0;
        unique case (state)
            ST_IDLE: ;
            ST_HEAD: begin
                fetch_addr = addr_head;
                req_n      = 1'b0;
                opc_n      = 1'b0;
                seq        = 1'b1;
                lr_we      = mem_ready;
                lr_wdata   = head_sum;
            end
            ST_REDIR: begin
                fetch_addr = addr_redir;
                req_n      = 1'b0;
                opc_n      = 1'b0;
                seq        = 1'b0;
            end
            ST_TARGET: begin
                fetch_addr = target;
                req_n      = 1'b0;
                opc_n      = 1'b0;
                seq        = 1'b1;
                lr_we      = mem_ready;
                lr_wdata   = ret_addr;
            end
            ST_REFILL: begin
                fetch_addr = target_p2;
                req_n      = 1'b0;
                opc_n      = 1'b0;
                seq        = 1'b1;
                lr_we      = mem_ready;
                lr_wdata   = ret_fixed;
            end
            ST_FIN: begin
                done        = 1'b1;
                resume_addr = target_p4;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/lbl_seq.sv
module lbl_seq
    import lbl_pkg::*;
#(
    parameter int AW       = 32,
    parameter int OFFW     = 11,
    parameter int HI_SHIFT = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [AW-1:0]   pc_in,
    input  logic [OFFW-1:0] hi_offset,
    input  logic [OFFW-1:0] lo_offset,
    input  logic            mem_ready,
    output logic [AW-1:0]   fetch_addr,
    output logic [1:0]      acc_size,
    output logic            bus_wr,
    output logic            req_n,
    output logic            seq,
    output logic            opc_n,
    output logic            lr_we,
    output logic [AW-1:0]   lr_wdata,
    output logic            done,
    output logic [AW-1:0]   resume_addr
);
    lbl_state_e      state;
    logic            accept;
    logic [AW-1:0]   pc_q;
    logic [OFFW-1:0] hi_q;
    logic [OFFW-1:0] lo_q;
    logic [AW-1:0]   addr_head, addr_redir, head_sum, target;
    logic [AW-1:0]   target_p2, target_p4, ret_addr, ret_fixed;

    lbl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mem_ready (mem_ready),
        .state     (state),
        .accept    (accept)
    );

    lbl_capture #(.AW(AW), .OFFW(OFFW)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .pc_in (pc_in),
        .hi_in (hi_offset),
        .lo_in (lo_offset),
        .pc_q  (pc_q),
        .hi_q  (hi_q),
        .lo_q  (lo_q)
    );

    lbl_addr_calc #(.AW(AW), .OFFW(OFFW), .HI_SHIFT(HI_SHIFT)) u_calc (
        .pc_q       (pc_q),
        .hi_q       (hi_q),
        .lo_q       (lo_q),
        .addr_head  (addr_head),
        .addr_redir (addr_redir),
        .head_sum   (head_sum),
        .target     (target),
        .target_p2  (target_p2),
        .target_p4  (target_p4),
        .ret_addr   (ret_addr),
        .ret_fixed  (ret_fixed)
    );

    lbl_bus_drive #(.AW(AW)) u_drv (
        .state       (state),
        .mem_ready   (mem_ready),
        .addr_head   (addr_head),
        .addr_redir  (addr_redir),
        .head_sum    (head_sum),
        .target      (target),
        .target_p2   (target_p2),
        .target_p4   (target_p4),
        .ret_addr    (ret_addr),
        .ret_fixed   (ret_fixed),
        .fetch_addr  (fetch_addr),
        .acc_size    (acc_size),
        .bus_wr      (bus_wr),
        .req_n       (req_n),
        .seq         (seq),
        .opc_n       (opc_n),
        .lr_we       (lr_we),
        .lr_wdata    (lr_wdata),
        .done        (done),
        .resume_addr (resume_addr)
    );
endmodule

// File: rtl/lbl_seq_chk.sv
module lbl_seq_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_ready,
    input logic [AW-1:0] fetch_addr,
    input logic [1:0]    acc_size,
    input logic          bus_wr,
    input logic          req_n,
    input logic          seq,
    input logic          opc_n,
    input logic          lr_we,
    input logic          done
);
    // R7
    bus_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_n |-> (acc_size == 2'b01 && !bus_wr && !opc_n));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_n && !mem_ready) |=> (!req_n && $stable(fetch_addr) && $stable(seq)));

    // R8
    stall_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ready |-> !lr_we);

    // R4
    redirect_then_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_n && !seq && mem_ready) |=> (!req_n && seq));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_n));

    // R1
    done_idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (req_n && opc_n && !lr_we));
endmodule

bind lbl_seq lbl_seq_chk #(.AW(AW)) u_lbl_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_ready  (mem_ready),
    .fetch_addr (fetch_addr),
    .acc_size   (acc_size),
    .bus_wr     (bus_wr),
    .req_n      (req_n),
    .seq        (seq),
    .opc_n      (opc_n),
    .lr_we      (lr_we),
    .done       (done)
);

// File: tb/tb_lbl_seq.sv
`timescale 1ns/1ps
module tb_lbl_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] pc_in = '0;
    logic [10:0] hi_offset = '0;
    logic [10:0] lo_offset = '0;
    logic        mem_ready = 1'b1;
    logic [31:0] fetch_addr, lr_wdata, resume_addr;
    logic [1:0]  acc_size;
    logic        bus_wr, req_n, seq, opc_n, lr_we, done;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    lbl_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .pc_in(pc_in),
        .hi_offset(hi_offset), .lo_offset(lo_offset), .mem_ready(mem_ready),
        .fetch_addr(fetch_addr), .acc_size(acc_size), .bus_wr(bus_wr),
        .req_n(req_n), .seq(seq), .opc_n(opc_n), .lr_we(lr_we),
        .lr_wdata(lr_wdata), .done(done), .resume_addr(resume_addr)
    );

    typedef struct packed {
        logic [31:0] pc;
        logic [10:0] hi;
        logic [10:0] lo;
        logic [31:0] head;
        logic [31:0] tgt;
        logic [1:0]  stall;
    } vec_t;

    // head = pc+4+sext(hi)<<12, tgt = head + lo<<1, worked out by hand
    localparam vec_t VECS [5] = '{
        '{32'h0000_1000, 11'h000, 11'h000, 32'h0000_1004, 32'h0000_1004, 2'd0},
        '{32'h0000_2000, 11'h001, 11'h002, 32'h0000_3004, 32'h0000_3008, 2'd1},
        '{32'h0001_0000, 11'h7FF, 11'h7FF, 32'h0000_F004, 32'h0001_0002, 2'd0},
        '{32'h0000_0100, 11'h400, 11'h005, 32'hFFC0_0104, 32'hFFC0_010E, 2'd2},
        '{32'hFFFF_FFF0, 11'h3FF, 11'h000, 32'h003F_EFF4, 32'h003F_EFF4, 2'd1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic idle_chk(input string tag);
        chk({tag, " req_n"}, 32'(req_n), 32'd1);
        chk({tag, " opc_n"}, 32'(opc_n), 32'd1);
        chk({tag, " lr_we"}, 32'(lr_we), 32'd0);
    endtask

    // entered at a falling edge with the design in the bus cycle under test
    task automatic bus_cycle(input string tag, input logic [31:0] addr, input logic exp_seq,
                             input logic exp_we, input logic [31:0] exp_wd, input int stall);
        for (int s = 0; s < stall; s++) begin
            mem_ready = 1'b0;
            #1;
            chk({tag, " R8 stall addr"}, fetch_addr, addr);
            chk({tag, " R8 stall seq"}, 32'(seq), 32'(exp_seq));
            chk({tag, " R8 stall lr_we"}, 32'(lr_we), 32'd0);
            @(negedge clk);
        end
        mem_ready = 1'b1;
        #1;
        chk({tag, " addr"}, fetch_addr, addr);
        chk({tag, " seq"}, 32'(seq), 32'(exp_seq));
        chk({tag, " R7 size/wr/req/opc"}, {26'd0, acc_size, bus_wr, req_n, opc_n, 1'b0},
            {26'd0, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0});
        chk({tag, " lr_we"}, 32'(lr_we), 32'(exp_we));
        if (exp_we) chk({tag, " lr_wdata"}, lr_wdata, exp_wd);
        @(negedge clk);
    endtask

    task automatic run_op(input vec_t v, input bit hold_start);
        @(negedge clk);
        start = 1'b1; pc_in = v.pc; hi_offset = v.hi; lo_offset = v.lo;
        @(negedge clk);
        // R2: scramble inputs after capture; optionally keep start high
        start = hold_start; pc_in = ~v.pc; hi_offset = ~v.hi; lo_offset = ~v.lo;
        bus_cycle("R3 head",   v.pc + 32'd4, 1'b1, 1'b1, v.head,        v.stall);
        bus_cycle("R4 redir",  v.pc + 32'd6, 1'b0, 1'b0, 32'd0,         v.stall);
        bus_cycle("R5 target", v.tgt,        1'b1, 1'b1, v.pc + 32'd6,  v.stall);
        bus_cycle("R6 refill", v.tgt + 32'd2, 1'b1, 1'b1, v.pc + 32'd4, v.stall);
        start = 1'b0;
        #1;
        chk("R9 done high", 32'(done), 32'd1);
        chk("R9 resume_addr R10", resume_addr, v.tgt + 32'd4);
        idle_chk("R1 fin");
        @(negedge clk);
        #1;
        chk("R9 done one cycle", 32'(done), 32'd0);
        idle_chk("R1 idle after op");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1;
        chk("R1 reset done", 32'(done), 32'd0);
        idle_chk("R1 reset");
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        idle_chk("R1 idle");

        // table of vectors
        for (int i = 0; i < 5; i++) run_op(VECS[i], 1'b0);

        // R2: start held high throughout a running operation is ignored
        run_op(VECS[1], 1'b1);

        // R1: reset in the middle of an operation returns to idle
        @(negedge clk);
        start = 1'b1; pc_in = VECS[0].pc; hi_offset = VECS[0].hi; lo_offset = VECS[0].lo;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        #1;
        chk("R4 mid-op redir addr", fetch_addr, VECS[0].pc + 32'd6);
        rst_n = 1'b0;
        #1;
        idle_chk("R1 mid-op reset");
        chk("R1 mid-op reset done", 32'(done), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        idle_chk("R1 after mid-op reset");

        // normal operation after recovery, with stalls
        run_op(VECS[3], 1'b0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule